// File: doc/BRIEF.md
# Four-Phase Video DAC Serializer

This block turns one pixel per pixel period into four consecutive words on a narrow bus to a video DAC. It runs on a single clock at four times the pixel rate. Each pixel brings a 7-bit red, green and blue value, a valid flag and four sync/control flags: composite sync, horizontal sync, clamp and vertical sync. The block sends red, then green, then blue. It then sends a word that packs the four flags in inverted form. A strobe beside the bus is high on the three colour words and low on the flag word, so the DAC can find the phase boundary.

A small state machine with four named states steps through the phases. Its transitions are RED→GREEN, GREEN→BLUE, BLUE→SYNC and SYNC→RED, with no other paths. The pixel and its flags are sampled on the clock edge that emits the red word. They are held in a register for the rest of that pixel period, so the upstream source only needs to present data once every four clocks. An asynchronous active-low reset parks the bus and restarts the sequence, so the first edge after release emits a red word.

Top module: `vdac_serializer`

## Requirements
- R1: The 7-bit bus `dac_bus` repeats a four-edge cycle of red, green, blue and sync words. The first edge after reset release emits red.
- R2: `dac_strobe` is 1 on the red, green and blue words and 0 on the sync word.
- R3: In the sync word, bit 0 is NOT `sync_comp`, bit 1 is NOT `sync_horiz`, bit 2 is NOT `sync_clamp` and bit 3 is NOT `sync_vert`. Bits 6 to 4 are 0.
- R4: All inputs are sampled on the edge that emits the red word. Input changes during the green, blue and sync words of that pixel do not change those words.
- R5: When `pix_valid` is 0 at the sampling edge, the red, green and blue words are 0. The sync word still encodes the sampled flags as in R3.
- R6: While `rst_n` is 0, `dac_bus` is 0 and `dac_strobe` is 0, taking effect without a clock edge. A reset in the middle of a pixel abandons it, and the next edge after release emits red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_valid | input | 1 | Pixel carries colour data |
| pix_red | input | 7 | Red channel |
| pix_green | input | 7 | Green channel |
| pix_blue | input | 7 | Blue channel |
| sync_comp | input | 1 | Composite sync flag, active high |
| sync_horiz | input | 1 | Horizontal sync flag, active high |
| sync_clamp | input | 1 | Clamp flag, active high |
| sync_vert | input | 1 | Vertical sync flag, active high |
| dac_bus | output | 7 | Multiplexed DAC data |
| dac_strobe | output | 1 | High on colour words, low on the sync word |

## Verification
If the phase state machine skips or repeats a state, the strobe no longer falls exactly once in every four edges. The colour order also shifts, and the mismatch is visible on the next word. A hold register that loads on the wrong phase shows up as green, blue or sync words that follow inputs scrambled after the red edge. That error appears within three edges of the fault. A broken inversion or a wrong lane of the sync nibble shows up in the first sync word that uses the affected flag. A reset that fails to realign shows up as a non-red word on the first edge after release.

// File: rtl/vdac_pkg.sv
package vdac_pkg;
    localparam int CHAN_W    = 7;
    localparam int FLAG_W    = 4;
    localparam int PHASE_CNT = 4;
    localparam int PHASE_W   = $clog2(PHASE_CNT);
    localparam int PAD_W     = CHAN_W - FLAG_W;

    typedef enum logic [PHASE_W-1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2,
        PH_SYNC  = 2'd3
    } phase_e;

    // flags: [0] composite, [1] horizontal, [2] clamp, [3] vertical
    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] red;
        logic [CHAN_W-1:0] green;
        logic [CHAN_W-1:0] blue;
        logic [FLAG_W-1:0] flags;
    } pixel_t;
endpackage

// File: rtl/vdac_phase_seq.sv
module vdac_phase_seq
    import vdac_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase,
    output logic   capture_en
);
    phase_e state_q;
    phase_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_RED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            PH_RED:   state_d = PH_GREEN;
            PH_GREEN: state_d = PH_BLUE;
            PH_BLUE:  state_d = PH_SYNC;
            PH_SYNC:  state_d = PH_RED;
            default:  state_d = PH_RED;
        endcase
    end

    always_comb begin
        phase      = state_q;
        capture_en = (state_q == PH_RED);
    end
endmodule

// File: rtl/vdac_pixel_hold.sv
module vdac_pixel_hold
    import vdac_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   capture_en,
    input  pixel_t live,
    output pixel_t held
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          held <= '0;
        else if (capture_en) held <= live;
    end
endmodule

// File: rtl/vdac_lane_mux.sv
module vdac_lane_mux
    import vdac_pkg::*;
(
    input  phase_e            phase,
    input  pixel_t            live,
    input  pixel_t            held,
    output logic [CHAN_W-1:0] word,
    output logic              strobe
);
    logic [CHAN_W-1:0] sync_word;

    always_comb begin
        sync_word = {{PAD_W{1'b0}}, ~held.flags};
    end

    always_comb begin
        unique case (phase)
            PH_RED: begin
                word   = live.valid ? live.red : '0;
                strobe = 1'b1;
            end
            PH_GREEN: begin
                word   = held.valid ? held.green : '0;
                strobe = 1'b1;
            end
            PH_BLUE: begin
                word   = held.valid ? held.blue : '0;
                strobe = 1'b1;
            end
            PH_SYNC: begin
                word   = sync_word;
                strobe = 1'b0;
            end
            default: begin
                word   = '0;
                strobe = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vdac_serializer.sv
module vdac_serializer
    import vdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic [CHAN_W-1:0] pix_red,
    input  logic [CHAN_W-1:0] pix_green,
    input  logic [CHAN_W-1:0] pix_blue,
    input  logic              sync_comp,
    input  logic              sync_horiz,
    input  logic              sync_clamp,
    input  logic              sync_vert,
    output logic [CHAN_W-1:0] dac_bus,
    output logic              dac_strobe
);
    phase_e            phase_q;
    logic              capture_en;
    pixel_t            live_px;
    pixel_t            held_px;
    logic [CHAN_W-1:0] word_d;
    logic              strobe_d;

    always_comb begin
        live_px.valid = pix_valid;
        live_px.red   = pix_red;
        live_px.green = pix_green;
        live_px.blue  = pix_blue;
        live_px.flags = {sync_vert, sync_clamp, sync_horiz, sync_comp};
    end

    vdac_phase_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase_q),
        .capture_en (capture_en)
    );

    vdac_pixel_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_en (capture_en),
        .live       (live_px),
        .held       (held_px)
    );

    vdac_lane_mux u_mux (
        .phase  (phase_q),
        .live   (live_px),
        .held   (held_px),
        .word   (word_d),
        .strobe (strobe_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_bus    <= '0;
            dac_strobe <= 1'b0;
        end else begin
            dac_bus    <= word_d;
            dac_strobe <= strobe_d;
        end
    end
endmodule

// File: rtl/vdac_serializer_checker.sv
module vdac_serializer_checker
    import vdac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic [CHAN_W-1:0] dac_bus,
    input logic              dac_strobe,
    input phase_e            phase_q
);
    // R2: a low strobe is followed by exactly three high ones
    assert_strobe_cadence_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_strobe |=> dac_strobe ##1 dac_strobe ##1 dac_strobe);

    // R3: pad bits of the sync word stay zero
    assert_sync_pad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_strobe |-> (dac_bus[CHAN_W-1:FLAG_W] == '0));

    // R5: red word after an invalid sample is dark
    assert_invalid_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_strobe && !$past(dac_strobe) && !$past(pix_valid)) |-> (dac_bus == '0));

    // R1: sequencer about to emit red only after a sync word or reset
    assert_red_follows_sync_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RED) |-> !dac_strobe);
endmodule

bind vdac_serializer vdac_serializer_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_valid  (pix_valid),
    .dac_bus    (dac_bus),
    .dac_strobe (dac_strobe),
    .phase_q    (phase_q)
);

// File: tb/vdac_serializer_test.sv
module vdac_serializer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0;
    logic [6:0] pix_red = '0, pix_green = '0, pix_blue = '0;
    logic       sync_comp = 1'b0, sync_horiz = 1'b0, sync_clamp = 1'b0, sync_vert = 1'b0;
    logic [6:0] dac_bus;
    logic       dac_strobe;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vdac_serializer uut (
        .clk (clk), .rst_n (rst_n), .pix_valid (pix_valid),
        .pix_red (pix_red), .pix_green (pix_green), .pix_blue (pix_blue),
        .sync_comp (sync_comp), .sync_horiz (sync_horiz),
        .sync_clamp (sync_clamp), .sync_vert (sync_vert),
        .dac_bus (dac_bus), .dac_strobe (dac_strobe)
    );

    task automatic check(input string req, input logic [7:0] exp);
        checks++;
        if ({dac_strobe, dac_bus} !== exp) begin
            errors++;
            $display("FAIL %s: got strobe/bus %h expected %h", req, {dac_strobe, dac_bus}, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [6:0] r, input logic [6:0] g,
                         input logic [6:0] b, input logic [3:0] f);
        pix_valid = v; pix_red = r; pix_green = g; pix_blue = b;
        {sync_vert, sync_clamp, sync_horiz, sync_comp} = f;
    endtask

    // Called just after a negedge with red due on the next posedge.
    task automatic send_pixel(input string req, input logic v, input logic [6:0] r,
                              input logic [6:0] g, input logic [6:0] b,
                              input logic [3:0] f, input bit scramble);
        drive(v, r, g, b, f);
        @(negedge clk);
        check(req, {1'b1, v ? r : 7'd0});
        if (scramble) drive(~v, ~r, ~g, ~b, ~f);
        @(negedge clk);
        check(req, {1'b1, v ? g : 7'd0});
        @(negedge clk);
        check(req, {1'b1, v ? b : 7'd0});
        @(negedge clk);
        check(req, {1'b0, 3'b000, ~f});
    endtask

    task automatic test_reset_state;
        check("R6 idle in reset", 8'h00);
        @(negedge clk);
        check("R6 idle in reset", 8'h00);
        rst_n = 1'b1;
    endtask

    task automatic test_order;
        send_pixel("R1 R2 order", 1'b1, 7'h11, 7'h22, 7'h33, 4'b0000, 1'b0);
        send_pixel("R1 R2 order", 1'b1, 7'h7f, 7'h00, 7'h55, 4'b1111, 1'b0);
        send_pixel("R1 R2 order", 1'b1, 7'h01, 7'h40, 7'h2a, 4'b0101, 1'b0);
    endtask

    task automatic test_sync_lanes;
        for (int i = 0; i < 16; i++)
            send_pixel("R3 sync lanes", 1'b1, 7'(i), 7'(i + 3), 7'(i + 9), 4'(i), 1'b0);
    endtask

    task automatic test_hold;
        send_pixel("R4 hold", 1'b1, 7'h15, 7'h6a, 7'h3c, 4'b1001, 1'b1);
        send_pixel("R4 hold", 1'b1, 7'h00, 7'h7f, 7'h01, 4'b0110, 1'b1);
    endtask

    task automatic test_invalid;
        send_pixel("R5 invalid", 1'b0, 7'h7f, 7'h7f, 7'h7f, 4'b1010, 1'b0);
        send_pixel("R5 invalid", 1'b0, 7'h12, 7'h34, 7'h56, 4'b0001, 1'b1);
    endtask

    task automatic test_midstream_reset;
        drive(1'b1, 7'h44, 7'h55, 7'h66, 4'b0011);
        @(negedge clk);
        check("R1 before reset", 8'hc4);
        @(negedge clk);
        check("R1 before reset", 8'hd5);
        rst_n = 1'b0;
        #1;
        check("R6 async clear", 8'h00);
        @(negedge clk);
        check("R6 held in reset", 8'h00);
        rst_n = 1'b1;
        send_pixel("R6 realign", 1'b1, 7'h0f, 7'h70, 7'h3e, 4'b1100, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        test_reset_state;
        test_order;
        test_sync_lanes;
        test_hold;
        test_invalid;
        test_midstream_reset;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule